// File: doc/BRIEF.md
# Rate-Change Clock Divider Controller

This block turns a clock into a transmit clock-enable strobe whose period is a selectable divide factor D of 1, 2, 4 or 8. A 3-bit rate code chooses D. One code falls back to a divider fixed by a parameter, four codes name D directly, and the remaining codes are reserved. The strobe is high for one cycle every D cycles, so logic downstream runs at the divided rate without a derived clock.

Each accepted change of the rate code starts a settling timer of `SETTLE_CYCLES` cycles. When the timer runs out without being restarted, the block raises a done output for one cycle. A new divide factor is not applied at once. It waits for the end of the strobe period that is in progress, so no period is ever cut short. A parameter chooses between two ways of taking in the rate code. In the default way the code is sampled directly, because it is already timed to this clock. In the other way it passes through a two-flop synchronizer first, because it may change at any time.

The block has no data stream and no handshake. All pins are plain control and status signals. Reset is synchronous and active high.

Top module: `rate_div_ctrl`

## Requirements
- R1: Rate code 3'b000 selects the divider given by parameter `DEFAULT_DIV`. Elaboration rejects any `DEFAULT_DIV` outside {1,2,4,8} and any `SETTLE_CYCLES` below 1.
- R2: Rate codes 3'b001, 3'b010, 3'b011 and 3'b100 select D = 1, 2, 4 and 8. `cur_div_o` reports D as a plain binary number, and it always has exactly one bit set.
- R3: Reserved codes 3'b101 to 3'b111 leave the divider as it is, but they still count as a change and produce a done pulse.
- R4: In synchronous mode, a code that differs from the last accepted code and is present at clock edge E raises `rate_done_o` in the cycle that follows edge E+SETTLE_CYCLES. The pulse lasts exactly one cycle.
- R5: Presenting the code that was last accepted has no effect: no done pulse follows and the divider does not change.
- R6: A new change that arrives while the timer is running restarts the timer. Only one done pulse follows, timed from the final change.
- R7: If a change is detected on the same edge where the timer would expire, the change wins. No pulse is issued for the earlier change, and the timer restarts.
- R8: `tx_ce_o` is high for one cycle in every D cycles. With D = 1 it stays high continuously.
- R9: The divider switches only on a cycle in which `tx_ce_o` is high. Every gap between consecutive strobes therefore equals either the old D or the new D.
- R10: With `ASYNC_RATE` = 1, the code passes through two flops before the change check, which adds two cycles to the R4 timing.
- R11: Reset loads `DEFAULT_DIV`, clears the timer, holds done low and sets the last accepted code to 3'b000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the whole block |
| rst | input | 1 | Synchronous active-high reset |
| rate_i | input | 3 | Rate code |
| tx_ce_o | output | 1 | Clock-enable strobe, one cycle every D cycles |
| rate_done_o | output | 1 | One-cycle pulse marking the end of a settling interval |
| cur_div_o | output | 4 | Divide factor currently in effect |

## Verification
The timer expiring and a new change being detected can fall on the same edge. The bench provokes this by presenting a second code exactly SETTLE_CYCLES cycles after the first. It then passes only if no pulse appears at the first deadline and exactly one appears SETTLE_CYCLES+1 cycles after the second code. A divider update can also coincide with a strobe boundary. This is judged by switching from D = 8 to D = 1 in the middle of a period and requiring every measured strobe gap to be 8 or 1.

// File: rtl/rdc_pkg.sv
package rdc_pkg;
  localparam int CODE_W = 3;
  localparam int DIV_W  = 4;

  typedef logic [CODE_W-1:0] rate_code_t;
  typedef logic [DIV_W-1:0]  div_t;

  typedef struct packed {
    logic keep;
    div_t div;
  } rate_dec_t;

  function automatic rate_dec_t decode_rate(input rate_code_t code, input div_t dflt);
    rate_dec_t r;
    r.keep = 1'b0;
    r.div  = dflt;
    case (code)
      3'b000:  r.div = dflt;
      3'b001:  r.div = 4'd1;
      3'b010:  r.div = 4'd2;
      3'b011:  r.div = 4'd4;
      3'b100:  r.div = 4'd8;
      default: r.keep = 1'b1;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/rdc_rate_sync.sv
module rdc_rate_sync
  import rdc_pkg::*;
#(
  parameter bit ASYNC_RATE = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  rate_code_t rate_i,
  output rate_code_t rate_o
);
  if (ASYNC_RATE) begin : g_sync
    rate_code_t meta_q, stable_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        meta_q   <= '0;
        stable_q <= '0;
      end else begin
        meta_q   <= rate_i;
        stable_q <= meta_q;
      end
    end
    assign rate_o = stable_q;
  end else begin : g_direct
    logic unused_clk_rst;
    assign unused_clk_rst = clk ^ rst;
    assign rate_o = rate_i;
  end
endmodule

// File: rtl/rdc_settle_timer.sv
module rdc_settle_timer #(
  parameter int SETTLE_CYCLES = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic done_o
);
  localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(SETTLE_CYCLES);

  logic [CNT_W-1:0] remain_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain_q <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        remain_q <= LOAD;
      end else if (remain_q == CNT_W'(1)) begin
        remain_q <= '0;
        done_o   <= 1'b1;
      end else if (remain_q != '0) begin
        remain_q <= remain_q - CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/rdc_ce_divider.sv
module rdc_ce_divider
  import rdc_pkg::*;
#(
  parameter int DEFAULT_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  div_t next_div_i,
  output logic ce_o,
  output div_t cur_div_o
);
  localparam div_t RESET_DIV = DIV_W'(DEFAULT_DIV);

  div_t phase_q;
  div_t div_q;

  assign ce_o      = (phase_q == div_q - DIV_W'(1));
  assign cur_div_o = div_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
      div_q   <= RESET_DIV;
    end else if (ce_o) begin
      phase_q <= '0;
      div_q   <= next_div_i;
    end else begin
      phase_q <= phase_q + DIV_W'(1);
    end
  end
endmodule

// File: rtl/rate_div_ctrl.sv
module rate_div_ctrl
  import rdc_pkg::*;
#(
  parameter int DEFAULT_DIV   = 4,
  parameter int SETTLE_CYCLES = 6,
  parameter bit ASYNC_RATE    = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] rate_i,
  output logic       tx_ce_o,
  output logic       rate_done_o,
  output logic [3:0] cur_div_o
);
  localparam div_t RESET_DIV = DIV_W'(DEFAULT_DIV);

  if (!(DEFAULT_DIV == 1 || DEFAULT_DIV == 2 || DEFAULT_DIV == 4 || DEFAULT_DIV == 8))
  begin : g_bad_div
    $error("rate_div_ctrl: DEFAULT_DIV must be 1, 2, 4 or 8");
  end
  if (SETTLE_CYCLES < 1) begin : g_bad_settle
    $error("rate_div_ctrl: SETTLE_CYCLES must be at least 1");
  end

  rate_code_t rate_s;
  rate_code_t accepted_q;
  div_t       pend_div_q;
  rate_dec_t  dec;
  logic       change;

  rdc_rate_sync #(.ASYNC_RATE(ASYNC_RATE)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .rate_i(rate_i),
    .rate_o(rate_s)
  );

  assign change = (rate_s != accepted_q);
  assign dec    = decode_rate(rate_s, RESET_DIV);

  always_ff @(posedge clk) begin
    if (rst) begin
      accepted_q <= '0;
      pend_div_q <= RESET_DIV;
    end else if (change) begin
      accepted_q <= rate_s;
      if (!dec.keep) pend_div_q <= dec.div;
    end
  end

  rdc_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .start_i(change),
    .done_o (rate_done_o)
  );

  rdc_ce_divider #(.DEFAULT_DIV(DEFAULT_DIV)) u_div (
    .clk       (clk),
    .rst       (rst),
    .next_div_i(pend_div_q),
    .ce_o      (tx_ce_o),
    .cur_div_o (cur_div_o)
  );
endmodule

// File: rtl/rdc_checker.sv
module rdc_checker #(
  parameter int DEFAULT_DIV = 4
) (
  input logic       clk,
  input logic       rst,
  input logic       ce,
  input logic       done,
  input logic [3:0] div
);
  // R4
  done_single_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);

  // R8
  ce_full_rate_chk: assert property (@(posedge clk) disable iff (rst) (div == 4'd1) |-> ce);

  // R9
  div_on_boundary_chk: assert property (@(posedge clk) disable iff (rst) !ce |=> $stable(div));

  // R2
  div_legal_chk: assert property (@(posedge clk) disable iff (rst) $countones(div) == 1);

  // R11
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (div == 4'(DEFAULT_DIV) && !done));
endmodule

bind rate_div_ctrl rdc_checker #(.DEFAULT_DIV(DEFAULT_DIV)) u_chk (
  .clk (clk),
  .rst (rst),
  .ce  (tx_ce_o),
  .done(rate_done_o),
  .div (cur_div_o)
);

// File: tb/tb_rate_div_ctrl.sv
module tb_rate_div_ctrl;
  localparam int S    = 6;
  localparam int DFLT = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] rate = 3'b000;
  logic       ce, done, ce_a, done_a;
  logic [3:0] div, div_a;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  rate_div_ctrl #(.DEFAULT_DIV(DFLT), .SETTLE_CYCLES(S), .ASYNC_RATE(1'b0)) dut (
    .clk(clk), .rst(rst), .rate_i(rate),
    .tx_ce_o(ce), .rate_done_o(done), .cur_div_o(div)
  );

  rate_div_ctrl #(.DEFAULT_DIV(DFLT), .SETTLE_CYCLES(S), .ASYNC_RATE(1'b1)) u_async (
    .clk(clk), .rst(rst), .rate_i(rate),
    .tx_ce_o(ce_a), .rate_done_o(done_a), .cur_div_o(div_a)
  );

  // {code, expected divider}
  localparam logic [6:0] VEC [0:7] = '{
    {3'b001, 4'd1}, {3'b011, 4'd4}, {3'b100, 4'd8}, {3'b000, 4'd4},
    {3'b010, 4'd2}, {3'b101, 4'd2}, {3'b111, 4'd2}, {3'b001, 4'd1}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic gap(output int g);
    g = 0;
    for (int i = 0; i < 20 && !ce; i++) step();
    for (int i = 0; i < 20; i++) begin
      step();
      g++;
      if (ce) break;
    end
  endtask

  // drive code at a negedge, then watch both done outputs for a window
  task automatic apply_watch(input logic [2:0] code, input int win,
                             output int first_s, output int pulses_s,
                             output int first_a, output int pulses_a);
    first_s = -1; pulses_s = 0; first_a = -1; pulses_a = 0;
    rate = code;
    for (int n = 1; n <= win; n++) begin
      step();
      if (done) begin pulses_s++; if (first_s < 0) first_s = n; end
      if (done_a) begin pulses_a++; if (first_a < 0) first_a = n; end
    end
  endtask

  initial begin
    int fs, ps, fa, pa, g;
    int bad_gaps;
    int prev;
    repeat (3) step();
    rst = 1'b0;
    step();
    // R11 reset state
    chk(div == 4'(DFLT), "R11 reset divider", div, DFLT);
    chk(!done, "R11 done low after reset", done, 0);
    gap(g);
    chk(g == DFLT, "R8 default strobe gap", g, DFLT);

    // vector table walk: R1 R2 R3 R4 R8 R10
    for (int v = 0; v < 8; v++) begin
      apply_watch(VEC[v][6:4], S + 8, fs, ps, fa, pa);
      chk(fs == S + 1 && ps == 1, "R4 sync done timing", fs, S + 1);
      chk(fa == S + 3 && pa == 1, "R10 async done timing", fa, S + 3);
      chk(div == VEC[v][3:0], "R1/R2/R3 divider for code", div, VEC[v][3:0]);
      gap(g);
      chk(g == int'(VEC[v][3:0]), "R8 strobe gap", g, VEC[v][3:0]);
    end

    // R5 same code again: no pulse, divider kept (current code 001, D=1)
    apply_watch(3'b001, 2 * S + 4, fs, ps, fa, pa);
    chk(ps == 0 && pa == 0, "R5 no pulse on same code", ps + pa, 0);
    chk(div == 4'd1, "R5 divider kept", div, 1);

    // R6 retrigger: change, 3 cycles later change again
    apply_watch(3'b010, 3, fs, ps, fa, pa);
    chk(ps == 0, "R6 no early pulse", ps, 0);
    apply_watch(3'b100, S + 8, fs, ps, fa, pa);
    chk(ps == 1 && fs == S + 1, "R6 single pulse after final change", fs, S + 1);
    chk(div == 4'd8, "R6 final divider", div, 8);

    // R7 change on the expiry edge
    apply_watch(3'b011, S, fs, ps, fa, pa);
    chk(ps == 0, "R7 no pulse before expiry", ps, 0);
    apply_watch(3'b100, S + 8, fs, ps, fa, pa);
    chk(ps == 1 && fs == S + 1, "R7 change wins over expiry", fs, S + 1);

    // R9 switch 8 -> 1 mid-period: every gap is 8 or 1
    step(); step(); step();
    rate = 3'b001;
    bad_gaps = 0;
    prev = -1;
    for (int n = 0; n < 48; n++) begin
      step();
      if (ce) begin
        if (prev >= 0 && !((n - prev) == 8 || (n - prev) == 1)) bad_gaps++;
        prev = n;
      end
    end
    chk(bad_gaps == 0, "R9 no shortened strobe gap", bad_gaps, 0);
    chk(div == 4'd1, "R9 new divider applied", div, 1);

    // R11 reset during settling
    rate = 3'b011;
    step(); step();
    rst = 1'b1;
    rate = 3'b000;
    step();
    chk(div == 4'(DFLT) && !done, "R11 reset mid-settle", div, DFLT);
    rst = 1'b0;
    fs = 0;
    for (int n = 0; n < S + 6; n++) begin
      step();
      if (done) fs++;
    end
    chk(fs == 0, "R11 timer cleared by reset", fs, 0);
    chk(div == 4'(DFLT), "R11 default divider kept", div, DFLT);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule